// File: doc/BRIEF.md
# One-Hot Scoreboard Dependency Matrix

This block keeps track of ordering hazards between a small pool of in-flight computation units and the architectural register file. Each unit slot holds a destination register mask and a source register mask. Every register identity and every unit identity is a single bit in a vector, never a binary index. A hazard between two slots is therefore found by ANDing bit vectors, with no comparator tree. The block grants each unit permission to read its operands (go-read) and permission to write its result (go-write). A read is held back while an older unit still owes a write to one of its source registers. A write is held back while an older unit still has to read the register about to be overwritten.

New work enters through a valid/ready issue port carrying a unit vector that may have several bits set. All selected units are loaded in the same cycle. Among units loaded together, the lower index is treated as older. An issue can be marked as speculative, meaning it follows an unresolved branch. Speculative units may read but may not write. When the branch resolves, a single-cycle input either lifts the shadow from every unit or returns every shadowed unit to idle, so that no wrong-path result ever reaches the registers.

Top module: `onehot_scoreboard`

## Requirements
- R1: After reset all units are idle, `go_rd`, `go_wr` and `unit_busy` are zero, and `issue_ready` is high for any request vector.
- R2: `issue_ready` is high exactly when no unit bit of `issue_units` belongs to a busy unit. An issue is accepted when `issue_valid` and `issue_ready` are both high. Each accepted unit is busy from the next cycle. A request held against back-pressure loads nothing. Units issued earlier are older than the new ones, and within one issue a lower unit index is older.
- R3: Bit u of `issue_units` selects unit u. Bits [u*NR +: NR] of `issue_dst` and `issue_src` hold the masks of unit u, with bit r meaning register r. Several units may be accepted in one cycle. A unit with an empty source mask is treated as having read its operands already.
- R4: `go_rd[u]` is high only while unit u is busy, has not read, and no older busy unit has a destination bit in common with u's source mask.
- R5: `go_wr[u]` is never high before unit u has read its operands (a `rd_ack` during `go_rd`).
- R6: `go_wr[u]` is low while any older unit that has not yet read has a source bit in common with u's destination mask.
- R7: A unit issued with `issue_shadow` high never gets `go_wr` until its shadow is lifted.
- R8: `br_resolve` with `br_ok` high clears the shadow of every busy unit in that cycle. Units issued in the same cycle keep the shadow they were issued with.
- R9: `br_resolve` with `br_ok` low returns every shadowed unit to idle at the next edge, releasing its age and hazard claims.
- R10: `rd_ack[u]` without `go_rd[u]`, and `wr_ack[u]` without `go_wr[u]`, have no effect.
- R11: `wr_ack[u]` during `go_wr[u]` makes unit u idle at the next edge and drops it from the age of every younger unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Issue request present |
| issue_ready | output | 1 | Requested units are all idle |
| issue_units | input | NU | One- or multi-hot unit selection |
| issue_dst | input | NU*NR | Destination masks, NR bits per unit |
| issue_src | input | NU*NR | Source masks, NR bits per unit |
| issue_shadow | input | 1 | Issued units follow an unresolved branch |
| br_resolve | input | 1 | Branch outcome is known this cycle |
| br_ok | input | 1 | Outcome: 1 keeps shadowed work, 0 cancels it |
| rd_ack | input | NU | Unit has read its operands |
| wr_ack | input | NU | Unit has written its result |
| go_rd | output | NU | Operand read permitted |
| go_wr | output | NU | Result write permitted |
| unit_busy | output | NU | Unit slot is occupied |

## Verification
A single-unit producer/consumer pair separates a correct read-after-write block from one that grants reads freely. A four-unit same-cycle issue, with a write-after-read pair and an empty source mask, tests same-cycle age ordering and the "already read" rule together. A speculative issue that is then cancelled shows that writes stay blocked and that the whole group clears in one edge. A second speculative issue that is then confirmed shows the shadow lifting without loss of work. Acknowledges given without grants, and an issue held against a busy unit, show that neither changes any state.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_UNITS = 4;
  localparam int unsigned SB_REGS  = 16;
endpackage

// File: rtl/sb_unit_row.sv
module sb_unit_row #(
  parameter int unsigned NU = sb_pkg::SB_UNITS,
  parameter int unsigned NR = sb_pkg::SB_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NR-1:0] ld_dst,
  input  logic [NR-1:0] ld_src,
  input  logic          ld_shadow,
  input  logic [NU-1:0] ld_older,
  input  logic [NU-1:0] free_vec,
  input  logic          rd_fire,
  input  logic          wr_fire,
  input  logic          br_clear,
  input  logic          br_cancel,
  output logic          busy_o,
  output logic          rdpend_o,
  output logic          shadow_o,
  output logic          free_o,
  output logic [NR-1:0] dst_o,
  output logic [NR-1:0] src_o,
  output logic [NU-1:0] older_o
);
  logic          busy_q, rdpend_q, shadow_q;
  logic [NR-1:0] dst_q, src_q;
  logic [NU-1:0] older_q;
  logic          kill;

  assign kill   = br_cancel & shadow_q & busy_q;
  assign free_o = wr_fire | kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rdpend_q <= 1'b0;
      shadow_q <= 1'b0;
      dst_q    <= '0;
      src_q    <= '0;
      older_q  <= '0;
    end else if (load) begin
      busy_q   <= 1'b1;
      rdpend_q <= |ld_src;
      shadow_q <= ld_shadow;
      dst_q    <= ld_dst;
      src_q    <= ld_src;
      older_q  <= ld_older;
    end else if (free_o) begin
      busy_q   <= 1'b0;
      rdpend_q <= 1'b0;
      shadow_q <= 1'b0;
      older_q  <= '0;
    end else begin
      if (rd_fire)  rdpend_q <= 1'b0;
      if (br_clear) shadow_q <= 1'b0;
      older_q <= older_q & ~free_vec;
    end
  end

  assign busy_o   = busy_q;
  assign rdpend_o = rdpend_q;
  assign shadow_o = shadow_q;
  assign dst_o    = dst_q;
  assign src_o    = src_q;
  assign older_o  = older_q;
endmodule

// File: rtl/sb_grant.sv
module sb_grant #(
  parameter int unsigned NU = sb_pkg::SB_UNITS,
  parameter int unsigned NR = sb_pkg::SB_REGS
) (
  input  logic [NU-1:0]         busy,
  input  logic [NU-1:0]         rdpend,
  input  logic [NU-1:0]         shadow,
  input  logic [NU-1:0][NR-1:0] dst,
  input  logic [NU-1:0][NR-1:0] src,
  input  logic [NU-1:0][NU-1:0] older,
  output logic [NU-1:0]         go_rd,
  output logic [NU-1:0]         go_wr
);
  logic [NU-1:0] raw_hit, war_hit;

  // Each hazard term is a plain AND of unary bits, reduced by OR.
  always_comb begin
    raw_hit = '0;
    war_hit = '0;
    for (int i = 0; i < NU; i++) begin
      for (int j = 0; j < NU; j++) begin
        raw_hit[i] = raw_hit[i] | (older[i][j] & busy[j]   & (|(dst[j] & src[i])));
        war_hit[i] = war_hit[i] | (older[i][j] & rdpend[j] & (|(src[j] & dst[i])));
      end
    end
  end

  assign go_rd = busy & rdpend & ~raw_hit;
  assign go_wr = busy & ~rdpend & ~shadow & ~war_hit;
endmodule

// File: rtl/onehot_scoreboard.sv
module onehot_scoreboard #(
  parameter int unsigned NU = sb_pkg::SB_UNITS,
  parameter int unsigned NR = sb_pkg::SB_REGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  output logic             issue_ready,
  input  logic [NU-1:0]    issue_units,
  input  logic [NU*NR-1:0] issue_dst,
  input  logic [NU*NR-1:0] issue_src,
  input  logic             issue_shadow,
  input  logic             br_resolve,
  input  logic             br_ok,
  input  logic [NU-1:0]    rd_ack,
  input  logic [NU-1:0]    wr_ack,
  output logic [NU-1:0]    go_rd,
  output logic [NU-1:0]    go_wr,
  output logic [NU-1:0]    unit_busy
);
  logic [NU-1:0][NR-1:0] dst_in, src_in, dst_q, src_q;
  logic [NU-1:0][NU-1:0] older_q;
  logic [NU-1:0]         busy, rdpend, shadow, freed, load;
  logic                  fire, br_clear, br_cancel;

  assign dst_in      = issue_dst;
  assign src_in      = issue_src;
  assign issue_ready = ~|(issue_units & busy);
  assign fire        = issue_valid & issue_ready;
  assign load        = issue_units & {NU{fire}};
  assign br_clear    = br_resolve & br_ok;
  assign br_cancel   = br_resolve & ~br_ok;

  for (genvar u = 0; u < NU; u++) begin : g_row
    localparam logic [NU-1:0] LOWER = (NU'(1) << u) - NU'(1);
    logic [NU-1:0] older_init;
    // Age row: everything still live is older, plus lower indices issued now.
    assign older_init = (busy & ~freed) | (load & LOWER);

    sb_unit_row #(.NU(NU), .NR(NR)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load[u]),
      .ld_dst   (dst_in[u]),
      .ld_src   (src_in[u]),
      .ld_shadow(issue_shadow),
      .ld_older (older_init),
      .free_vec (freed),
      .rd_fire  (rd_ack[u] & go_rd[u]),
      .wr_fire  (wr_ack[u] & go_wr[u]),
      .br_clear (br_clear),
      .br_cancel(br_cancel),
      .busy_o   (busy[u]),
      .rdpend_o (rdpend[u]),
      .shadow_o (shadow[u]),
      .free_o   (freed[u]),
      .dst_o    (dst_q[u]),
      .src_o    (src_q[u]),
      .older_o  (older_q[u])
    );

    a_r2_issue_busy: assert property (@(posedge clk) disable iff (!rst_n)
      load[u] |=> busy[u]);
    a_r5_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
      go_wr[u] |-> !rdpend[u]);
    a_r7_shadow_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      shadow[u] |-> !go_wr[u]);
    a_r8_shadow_lifted: assert property (@(posedge clk) disable iff (!rst_n)
      (br_clear && !load[u]) |=> !shadow[u]);
    a_r9_cancel_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (br_cancel && shadow[u] && !load[u]) |=> !busy[u]);
    a_r10_stray_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack[u] && !go_rd[u] && rdpend[u] && !br_resolve) |=> rdpend[u]);
    a_r11_write_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ack[u] && go_wr[u]) |=> !busy[u]);
  end

  sb_grant #(.NU(NU), .NR(NR)) u_grant (
    .busy  (busy),
    .rdpend(rdpend),
    .shadow(shadow),
    .dst   (dst_q),
    .src   (src_q),
    .older (older_q),
    .go_rd (go_rd),
    .go_wr (go_wr)
  );

  assign unit_busy = busy;
endmodule

// File: tb/onehot_scoreboard_bench.sv
module onehot_scoreboard_bench;
  localparam int NU = 4;
  localparam int NR = 16;
  localparam time CLK_PERIOD = 10;

  typedef struct packed {
    logic          iv;
    logic [3:0]    iu;
    logic [63:0]   dst;
    logic [63:0]   src;
    logic          sh;
    logic          rs;
    logic          ok;
    logic [3:0]    ra;
    logic [3:0]    wa;
    logic [3:0]    e_rd;
    logic [3:0]    e_wr;
    logic [3:0]    e_bsy;
    logic [23:0]   tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    // R4: u0 r1<-r2, u1 r3<-r1 waits on u0
    '{1'b1, 4'b0011, {16'h0000,16'h0000,16'h0008,16'h0002}, {16'h0000,16'h0000,16'h0002,16'h0004},
      1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0001, 4'b0000, 4'b0011, "R4 "},
    // R5: u0 reads, only then writes
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'b0000, 4'b0000, 4'b0001, 4'b0011, "R5 "},
    // R11: u0 writes back, u1 may read
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0001, 4'b0010, 4'b0000, 4'b0010, "R11"},
    // R2: shadowed issue u0 r6<-r3, u2 r5<-r6; u1 reads
    '{1'b1, 4'b0101, {16'h0000,16'h0020,16'h0000,16'h0040}, {16'h0000,16'h0040,16'h0000,16'h0008},
      1'b1, 1'b0, 1'b0, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0111, "R2 "},
    // R4: u1 done, u0 reads, u2 still waits on u0
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0010, 4'b0001, 4'b0000, 4'b0101, "R4 "},
    // R7: u0 has read but is shadowed
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0101, "R7 "},
    // R10: acks without grants
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 4'b0100, 4'b0001, 4'b0000, 4'b0000, 4'b0101, "R10"},
    // R9: branch fails, shadowed u0 and u2 cancelled
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, "R9 "},
    // R3: four-unit issue; u3 has no sources
    '{1'b1, 4'b1111, {16'h0080,16'h8000,16'h0004,16'h0001}, {16'h0000,16'h0010,16'h0001,16'h8000},
      1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0101, 4'b1000, 4'b1111, "R3 "},
    // R6: u2 read r4 but must not overwrite r15 before u0 reads it
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 4'b0100, 4'b1000, 4'b0001, 4'b0000, 4'b0111, "R6 "},
    // R6: u0 reads r15, u2 released
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'b0000, 4'b0000, 4'b0101, 4'b0111, "R6 "},
    // R11
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0101, 4'b0010, 4'b0000, 4'b0010, "R11"},
    // R7: shadowed u0 r9<-r10 issued while u1 reads
    '{1'b1, 4'b0001, {16'h0000,16'h0000,16'h0000,16'h0200}, {16'h0000,16'h0000,16'h0000,16'h0400},
      1'b1, 1'b0, 1'b0, 4'b0010, 4'b0000, 4'b0001, 4'b0010, 4'b0011, "R7 "},
    // R8: branch confirmed, u0 may now write
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b1, 1'b1, 4'b0001, 4'b0000, 4'b0000, 4'b0011, 4'b0011, "R8 "},
    // R11
    '{1'b0, 4'b0000, 64'h0, 64'h0, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0011, 4'b0000, 4'b0000, 4'b0000, "R11"}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             issue_valid = 1'b0;
  logic             issue_ready;
  logic [NU-1:0]    issue_units = '0;
  logic [NU*NR-1:0] issue_dst = '0;
  logic [NU*NR-1:0] issue_src = '0;
  logic             issue_shadow = 1'b0;
  logic             br_resolve = 1'b0;
  logic             br_ok = 1'b0;
  logic [NU-1:0]    rd_ack = '0;
  logic [NU-1:0]    wr_ack = '0;
  logic [NU-1:0]    go_rd, go_wr, unit_busy;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onehot_scoreboard #(.NU(NU), .NR(NR)) u_onehot_scoreboard (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_units(issue_units),
    .issue_dst(issue_dst), .issue_src(issue_src), .issue_shadow(issue_shadow),
    .br_resolve(br_resolve), .br_ok(br_ok), .rd_ack(rd_ack), .wr_ack(wr_ack),
    .go_rd(go_rd), .go_wr(go_wr), .unit_busy(unit_busy)
  );

  task automatic chk(input string req, input string what, input logic [NU-1:0] act,
                     input logic [NU-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    issue_valid = 1'b0; issue_units = '0; issue_dst = '0; issue_src = '0;
    issue_shadow = 1'b0; br_resolve = 1'b0; br_ok = 1'b0; rd_ack = '0; wr_ack = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    issue_units = 4'b1111;
    #1;
    chk("R1", "issue_ready", {3'b000, issue_ready}, 4'b0001);
    chk("R1", "unit_busy", unit_busy, 4'b0000);
    chk("R1", "go_rd", go_rd, 4'b0000);
    chk("R1", "go_wr", go_wr, 4'b0000);
    idle_inputs();
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      issue_valid = TBL[k].iv; issue_units = TBL[k].iu;
      issue_dst = TBL[k].dst;  issue_src = TBL[k].src; issue_shadow = TBL[k].sh;
      br_resolve = TBL[k].rs;  br_ok = TBL[k].ok;
      rd_ack = TBL[k].ra;      wr_ack = TBL[k].wa;
      @(posedge clk);
      #1;
      chk(string'(TBL[k].tag), $sformatf("row %0d go_rd", k), go_rd, TBL[k].e_rd);
      chk(string'(TBL[k].tag), $sformatf("row %0d go_wr", k), go_wr, TBL[k].e_wr);
      chk(string'(TBL[k].tag), $sformatf("row %0d busy", k), unit_busy, TBL[k].e_bsy);
    end

    // R2: back-pressure against a busy unit
    @(negedge clk);
    idle_inputs();
    issue_valid = 1'b1; issue_units = 4'b0001;
    issue_dst = {48'h0, 16'h0002}; issue_src = {48'h0, 16'h0004};
    @(negedge clk);
    issue_units = 4'b0011;
    issue_dst = {32'h0, 16'h0010, 16'h0002};
    issue_src = {32'h0, 16'h0020, 16'h0004};
    #1;
    chk("R2", "ready with busy unit requested", {3'b000, issue_ready}, 4'b0000);
    @(posedge clk);
    #1;
    chk("R2", "busy after refused issue", unit_busy, 4'b0001);
    @(negedge clk);
    issue_units = 4'b0010;
    #1;
    chk("R2", "ready for idle unit", {3'b000, issue_ready}, 4'b0001);
    @(posedge clk);
    #1;
    chk("R2", "busy after accepted issue", unit_busy, 4'b0011);
    chk("R4", "independent units both read", go_rd, 4'b0011);
    @(negedge clk);
    idle_inputs();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule